// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block turns an arbitrary reference clock into a one-cycle tick enable at an average rate of 1 MHz, and keeps a free-running 32-bit upward counter of those ticks. The rate is set as a fraction rather than a terminal count. A 16-bit configuration word holds a numerator and a denominator, each stored minus one. On every active reference cycle an accumulator gains the numerator. Each time it reaches the denominator, the denominator is taken off and a tick goes out. A reference rate such as 19.2 MHz therefore gives an exact microsecond rate with the ratio 5/96.

Software reaches the block through a small register port with combinational read data. The port gives access to the microsecond count (read only), the configuration word and a freeze bit. While the freeze bit is set, the count, the accumulator and the tick all stand still. Downstream timers use the tick output as their clock enable. The asynchronous active-low reset is released synchronously inside the block.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset the count reads 0, the configuration reads 0x0000000B, the freeze bit reads 0 and the tick is low.
- R2: The configuration word at offset 0x14 keeps numerator-minus-one in bits 15:8 and denominator-minus-one in bits 7:0. It reads back exactly as written in bits 15:0, and bits 31:16 read as zero.
- R3: In each cycle with no configuration write and no freeze, the accumulator gains numerator+1. When the sum reaches denominator+1, that amount is subtracted and the tick is high for the following cycle. K such cycles after a configuration write, floor(K*(N+1)/(D+1)) ticks have been produced, where N and D are the two stored fields and N is not greater than D.
- R4: The words 0x000B, 0x000C, 0x0019 and 0x045F give exactly 100 ticks in 1200, 1300, 2600 and 1920 reference cycles respectively, and only 99 ticks one cycle earlier.
- R5: The 32-bit count at offset 0x10 rises by one on the same clock edge that raises the tick, and is otherwise unchanged. Writes to offset 0x10 are ignored.
- R6: Bit 0 at offset 0x4C is the freeze bit. It reads back as written. While it is 1, the count, the accumulator and the tick are held, and the tick stays low.
- R7: A write to the configuration word clears the accumulator, and no tick comes from that cycle, even when the sum would have reached the denominator.
- R8: Other offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, sampled with bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when not selected |
| tick_o | output | 1 | One-cycle 1 MHz tick enable |

## Verification
A configuration write can land on the very cycle in which the accumulator would reach the denominator. The bench provokes this with the ratio 1/12: after eleven free cycles, the twelfth cycle carries a rewrite of the same word. The count must stay flat, and the first tick must then arrive twelve cycles after the write, not at once. A freeze write also coincides with an accumulation step. Its effect is judged by exact tick totals once the freeze is lifted.

// File: rtl/usec_tick_pkg.sv
`timescale 1ns/1ps
package usec_tick_pkg;
  localparam int FRAC_W = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 2 * FRAC_W;

  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FREEZE = 8'h4C;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;
    logic [FRAC_W-1:0] den_m1;
  } rate_cfg_t;
endpackage

// File: rtl/usec_rst_sync.sv
`timescale 1ns/1ps
module usec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/usec_rate_accum.sv
`timescale 1ns/1ps
module usec_rate_accum
  import usec_tick_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rate_cfg_t cfg_i,
  input  logic      freeze_i,
  input  logic      clear_i,
  output logic      roll_o,
  output logic      tick_o
);
  localparam int ACC_W = FRAC_W + 2;

  logic [ACC_W-1:0] acc_q, acc_d, num, den, sum;
  logic             acc_en, tick_q, tick_d;

  assign num = {2'b00, cfg_i.num_m1} + ACC_W'(1);
  assign den = {2'b00, cfg_i.den_m1} + ACC_W'(1);
  assign sum = acc_q + num;

  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    tick_d = 1'b0;
    if (clear_i) begin
      acc_d  = '0;
      acc_en = 1'b1;
    end else if (!freeze_i) begin
      acc_en = 1'b1;
      if (sum >= den) begin
        acc_d  = sum - den;
        tick_d = 1'b1;
      end else begin
        acc_d  = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign roll_o = tick_d;
  assign tick_o = tick_q;

  assert_acc_below_den_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.num_m1 <= cfg_i.den_m1) |-> (acc_q < den));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_q == '0) && !tick_o);

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !clear_i) |=> (acc_q == $past(acc_q)) && !tick_o);
endmodule

// File: rtl/usec_counter.sv
`timescale 1ns/1ps
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/usec_reg_file.sv
`timescale 1ns/1ps
module usec_reg_file
  import usec_tick_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count_i,
  output rate_cfg_t         cfg_o,
  output logic              freeze_o,
  output logic              cfg_wr_o
);
  rate_cfg_t cfg_q, cfg_d;
  logic      frz_q, frz_d, frz_we;
  logic      unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CFG_W];

  always_comb begin
    cfg_wr_o = bus_sel && bus_wr && (bus_addr == OFS_CFG);
    frz_we   = bus_sel && bus_wr && (bus_addr == OFS_FREEZE);
    cfg_d    = rate_cfg_t'(bus_wdata[CFG_W-1:0]);
    frz_d    = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= rate_cfg_t'(CFG_RST);
    else if (cfg_wr_o) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frz_q <= 1'b0;
    else if (frz_we) frz_q <= frz_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFS_COUNT:  bus_rdata = DATA_W'(count_i);
        OFS_CFG:    bus_rdata = DATA_W'(cfg_q);
        OFS_FREEZE: bus_rdata = DATA_W'(frz_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign cfg_o    = cfg_q;
  assign freeze_o = frz_q;

  assert_cfg_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |=> (cfg_q == $past(bus_wdata[CFG_W-1:0])));

  assert_other_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr != OFS_CFG) && (bus_addr != OFS_FREEZE))
      |=> $stable(cfg_q) && $stable(frz_q));
endmodule

// File: rtl/usec_tick_gen.sv
`timescale 1ns/1ps
module usec_tick_gen
  import usec_tick_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               SYNC_ST = 2,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_o
);
  logic             rst_n_s, roll, frz, cfg_wr;
  rate_cfg_t        cfg;
  logic [CNT_W-1:0] count;

  usec_rst_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s));

  usec_reg_file #(.CNT_W(CNT_W), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_i(count), .cfg_o(cfg), .freeze_o(frz), .cfg_wr_o(cfg_wr));

  usec_rate_accum u_accum (
    .clk(clk), .rst_n(rst_n_s), .cfg_i(cfg), .freeze_i(frz),
    .clear_i(cfg_wr), .roll_o(roll), .tick_o(tick_o));

  usec_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n_s), .inc_i(roll), .count_o(count));

  assert_tick_with_count_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tick_o) |-> (count == $past(count) + CNT_W'(1)));

  assert_frozen_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frz && !cfg_wr) |=> !tick_o);
endmodule

// File: tb/test_usec_tick_gen.sv
`timescale 1ns/1ps
module test_usec_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] c0, rd;

  always #5 clk = ~clk;

  usec_tick_gen i_usec_tick_gen (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_o(tick_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; drives a write over the next posedge, returns at the next negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rate_run(input string req, input logic [15:0] cfg, input int k, input int exp_n);
    bus_read(8'h10, c0);
    bus_write(8'h14, {16'h0, cfg});
    bus_read(8'h14, rd);
    check(req, rd, {16'h0, cfg});
    repeat (k - 1) @(negedge clk);
    bus_read(8'h10, rd);
    check(req, rd - c0, 32'((exp_n * (k - 1)) == 0 ? 0 : 0) + 32'(((k - 1) * (int'(cfg[15:8]) + 1)) / (int'(cfg[7:0]) + 1)));
    @(negedge clk);
    bus_read(8'h10, rd);
    check(req, rd - c0, 32'(exp_n));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int tick_seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(8'h10, rd); check("R1 count", rd, 32'h0);
    bus_read(8'h14, rd); check("R1 cfg", rd, 32'h0000000B);
    bus_read(8'h4C, rd); check("R1 freeze", rd, 32'h0);
    check("R1 tick", {31'h0, tick_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 the four standard encodings, exact 100 ticks
    rate_run("R4 12MHz", 16'h000B, 1200, 100);
    rate_run("R4 13MHz", 16'h000C, 1300, 100);
    rate_run("R4 26MHz", 16'h0019, 2600, 100);
    rate_run("R4 19.2MHz", 16'h045F, 1920, 100);

    // R3 near-exhaustive sweep of small ratios
    for (int n = 0; n < 4; n++) begin
      for (int d = n; d < n + 7; d++) begin
        rate_run("R3 sweep", {8'(n), 8'(d)}, 97, (97 * (n + 1)) / (d + 1));
      end
    end

    // R2 upper bits dropped, exact readback of the low half
    bus_write(8'h14, 32'hFFFF0A3C);
    bus_read(8'h14, rd); check("R2 readback", rd, 32'h00000A3C);

    // R7 config write on the overflow cycle
    bus_read(8'h10, c0);
    bus_write(8'h14, 32'h0000000B);
    repeat (11) @(negedge clk);
    bus_write(8'h14, 32'h0000000B);
    bus_read(8'h10, rd); check("R7 no tick on clear", rd, c0);
    check("R7 tick low", {31'h0, tick_o}, 32'h0);
    repeat (11) @(negedge clk);
    bus_read(8'h10, rd); check("R7 restart", rd, c0);
    @(negedge clk);
    bus_read(8'h10, rd); check("R5 count with tick", rd, c0 + 32'd1);
    check("R3 tick high", {31'h0, tick_o}, 32'h1);
    @(negedge clk);
    check("R3 tick one cycle", {31'h0, tick_o}, 32'h0);

    // R6 freeze; write at that edge still accumulates one step
    bus_read(8'h10, c0);
    bus_write(8'h14, 32'h0000000B);
    bus_write(8'h4C, 32'h1);
    bus_read(8'h4C, rd); check("R6 freeze readback", rd, 32'h1);
    tick_seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick_o) tick_seen++;
    end
    check("R6 no tick while frozen", 32'(tick_seen), 32'h0);
    bus_write(8'h10, 32'hDEADBEEF);
    bus_read(8'h10, rd); check("R5 count write ignored", rd, c0);
    bus_write(8'h20, 32'hFFFFFFFF);
    bus_read(8'h20, rd); check("R8 unmapped reads zero", rd, 32'h0);
    bus_read(8'h14, rd); check("R8 cfg untouched", rd, 32'h0000000B);
    bus_read(8'h4C, rd); check("R8 freeze untouched", rd, 32'h1);
    bus_write(8'h4C, 32'h0);
    repeat (10) @(negedge clk);
    bus_read(8'h10, rd); check("R6 accumulator held", rd, c0);
    @(negedge clk);
    bus_read(8'h10, rd); check("R6 resumes", rd, c0 + 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule